// File: doc/BRIEF.md
# Fuse-Programmed Registered Logic Array

This block models a small field-programmable sum-of-products device. A fuse-map vector of 2560 bits programs an AND plane of 40 columns by 64 product-term rows. Twenty logical signals feed the plane, each as a true and a complemented column: dedicated input pins, internal register feedback and I/O pin feedback. The 64 product terms are split into eight output macrocells of eight terms each.

A macrocell is either registered or combinational, and the parameter `NUM_REG` picks how many are registered (0, 4, 6 or 8). The registered cells sit in the middle of the row. A registered cell ORs its eight terms into a D flip-flop. All flip-flops share one clock and one active-low output enable, and their outputs feed back into the plane, so counters and state machines need no outside wiring. A combinational cell spends one term on its own 3-state enable and ORs the other seven. A reset clears every register. A test-load input lets the levels on the registered pins be clocked straight into the registers.

Top module: `pal_fuse_array`

## Requirements
- R1: Fuse bit index equals row*40 + column. Column 2k carries array signal k, and column 2k+1 carries its complement. A fuse bit of 1 means blown (column removed) and a bit of 0 means intact (column connected).
- R2: A product term is the AND of its intact columns. A term that keeps both columns of one signal is 0, and a term with every fuse blown is 1.
- R3: Macrocell m owns rows 8m to 8m+7. A registered cell loads the OR of all eight terms on each rising clock edge.
- R4: A combinational cell drives pin_oe[m] from row 8m and drives pin_out[m] with the inverse of the OR of rows 8m+1 to 8m+7.
- R5: A registered pin shows the inverse of its register. Its pin_oe is high only when oe_n is low and preload is low.
- R6: Array signals 0 to 11 are in_pins[11:0]. Signal 12+m is the register of macrocell m when that cell is registered, and pin_in[m] when it is not. With NUM_REG=0, signals 12 and 19 come from in_pins[12] and in_pins[13]. Registered cells are m = (8-NUM_REG)/2 up to (8+NUM_REG)/2-1.
- R7: While rst_n is low, every register is 0 at once, so every registered pin reads 1.
- R8: While preload is high, registered pins are released and each rising edge loads the inverse of pin_in[m], ignoring the array. After preload falls, the pin shows the level that was applied.
- R9: Reset release is synchronised. The first two rising edges after rst_n rises leave the registers at 0, and the third edge loads from the array.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Common register clock |
| rst_n | input | 1 | Asynchronous active-low clear |
| in_pins | input | 14 | Dedicated inputs; bits 13:12 used only when NUM_REG=0 |
| oe_n | input | 1 | Shared active-low enable of the registered pins |
| preload | input | 1 | Test-load mode for the registers |
| fuse_map | input | 2560 | Programming vector, 1 = blown |
| pin_in | input | 8 | Level seen on each I/O pin |
| pin_out | output | 8 | Value driven on each pin |
| pin_oe | output | 8 | Drive enable of each pin |

## Verification
The test load and the array's own next state are both candidates for the same clock edge. The bench holds preload high across edges while a programmed 4-bit counter would otherwise advance. It then judges that the pins show the applied pattern, not the count, and that counting resumes from that pattern's register value. An asynchronous clear issued mid-count is also checked against the resynchronised restart.

// File: rtl/pal_pkg.sv
package pal_pkg;
  localparam int PAL_INPUTS        = 14;
  localparam int PAL_MACROCELLS    = 8;
  localparam int PAL_TERMS_PER_MC  = 8;
  localparam int PAL_SHARED_INPUTS = 2;
endpackage

// File: rtl/pal_reset_sync.sv
module pal_reset_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] chain_q, chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= chain_d;
  end

  assign rst_sync_n = chain_q[STAGES-1];
endmodule

// File: rtl/pal_and_array.sv
module pal_and_array #(
  parameter int N_SIG = 20,
  parameter int N_ROW = 64,
  localparam int N_COL = 2 * N_SIG
) (
  input  logic [N_SIG-1:0]       sig,
  input  logic [N_ROW*N_COL-1:0] fuse,
  output logic [N_ROW-1:0]       term
);
  logic [N_COL-1:0] col;

  // R1: even column true, odd column complement
  for (genvar k = 0; k < N_SIG; k++) begin : g_col
    assign col[2*k]   = sig[k];
    assign col[2*k+1] = ~sig[k];
  end

  // R2: blown fuse (1) forces its column to 1, removing it from the AND
  for (genvar r = 0; r < N_ROW; r++) begin : g_row
    assign term[r] = &(col | fuse[r*N_COL +: N_COL]);
  end
endmodule

// File: rtl/pal_macrocell.sv
module pal_macrocell #(
  parameter bit REGISTERED = 1'b1,
  parameter int TPM        = 8
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [TPM-1:0] terms,
  input  logic           oe_n,
  input  logic           preload,
  input  logic           pin_in,
  output logic           pin_out,
  output logic           pin_oe,
  output logic           fb
);
  if (REGISTERED) begin : g_reg
    logic q, q_nxt, sum, ld_en;

    assign sum   = |terms;
    assign ld_en = 1'b1;

    always_comb begin
      q_nxt = q;
      if (ld_en) begin
        if (preload) q_nxt = ~pin_in;
        else         q_nxt = sum;
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) q <= 1'b0;
      else        q <= q_nxt;
    end

    assign pin_out = ~q;
    assign pin_oe  = ~oe_n & ~preload;
    assign fb      = q;

    p_preload_hiz_r8: assert property (@(posedge clk) disable iff (!rst_n)
      preload |-> !pin_oe);
    p_preload_load_r8: assert property (@(posedge clk) disable iff (!rst_n)
      preload |=> (pin_out == $past(pin_in)));
    p_array_load_r3: assert property (@(posedge clk) disable iff (!rst_n)
      !preload |=> (q == $past(sum)));
    always @(posedge rst_n) begin
      p_clear_r7: assert (q == 1'b0);
    end
  end else begin : g_comb
    logic sink_unused;
    assign sink_unused = clk ^ rst_n ^ oe_n ^ preload;
    assign pin_oe  = terms[0];
    assign pin_out = ~(|terms[TPM-1:1]);
    assign fb      = pin_in;
  end
endmodule

// File: rtl/pal_fuse_array.sv
module pal_fuse_array
  import pal_pkg::*;
#(
  parameter int NUM_REG = 4,
  parameter int N_IN    = PAL_INPUTS,
  parameter int N_MC    = PAL_MACROCELLS,
  parameter int TPM     = PAL_TERMS_PER_MC,
  localparam int N_DED     = N_IN - PAL_SHARED_INPUTS,
  localparam int N_SIG     = N_DED + N_MC,
  localparam int N_COL     = 2 * N_SIG,
  localparam int N_ROW     = N_MC * TPM,
  localparam int N_FUSE    = N_ROW * N_COL,
  localparam int FIRST_REG = (N_MC - NUM_REG) / 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [N_IN-1:0]   in_pins,
  input  logic              oe_n,
  input  logic              preload,
  input  logic [N_FUSE-1:0] fuse_map,
  input  logic [N_MC-1:0]   pin_in,
  output logic [N_MC-1:0]   pin_out,
  output logic [N_MC-1:0]   pin_oe
);
  logic             rst_sync_n;
  logic [N_SIG-1:0] sig;
  logic [N_ROW-1:0] term;
  logic [N_MC-1:0]  ext_in;
  logic [N_MC-1:0]  mc_fb;

  pal_reset_sync #(.STAGES(2)) u_rst (
    .clk       (clk),
    .rst_n     (rst_n),
    .rst_sync_n(rst_sync_n)
  );

  assign sig[N_DED-1:0] = in_pins[N_DED-1:0];

  pal_and_array #(.N_SIG(N_SIG), .N_ROW(N_ROW)) u_plane (
    .sig (sig),
    .fuse(fuse_map),
    .term(term)
  );

  for (genvar m = 0; m < N_MC; m++) begin : g_mc
    localparam bit IS_REG  = (m >= FIRST_REG) && (m < FIRST_REG + NUM_REG);
    localparam bit IS_EDGE = (NUM_REG == 0) && ((m == 0) || (m == N_MC - 1));

    // R6: edge cells of the all-combinational variant take extra inputs
    if (IS_EDGE) begin : g_edge
      assign ext_in[m] = (m == 0) ? in_pins[N_IN-2] : in_pins[N_IN-1];
    end else begin : g_io
      assign ext_in[m] = pin_in[m];
    end

    pal_macrocell #(.REGISTERED(IS_REG), .TPM(TPM)) u_cell (
      .clk    (clk),
      .rst_n  (rst_sync_n),
      .terms  (term[m*TPM +: TPM]),
      .oe_n   (oe_n),
      .preload(preload),
      .pin_in (ext_in[m]),
      .pin_out(pin_out[m]),
      .pin_oe (pin_oe[m]),
      .fb     (mc_fb[m])
    );

    assign sig[N_DED+m] = mc_fb[m];
  end

  if (NUM_REG == 0) begin : g_sink_l
    logic spare_unused;
    assign spare_unused = pin_in[0] ^ pin_in[N_MC-1];
  end else begin : g_sink_r
    logic spare_unused;
    assign spare_unused = in_pins[N_IN-1] ^ in_pins[N_IN-2];
  end
endmodule

// File: tb/test_pal_fuse_array.sv
module test_pal_fuse_array;
  localparam int NROW = 64;
  localparam int NCOL = 40;

  logic          clk = 1'b0;
  logic          rst_n;
  logic [13:0]   in_pins;
  logic          oe_n;
  logic          preload;
  logic [2559:0] fm;
  logic [7:0]    pin_in;
  logic [7:0]    pin_out;
  logic [7:0]    pin_oe;

  int n_chk = 0;
  int n_bad = 0;
  int exp_cnt;
  bit done = 0;

  always #2 clk = ~clk;

  pal_fuse_array #(.NUM_REG(4)) i_pal_fuse_array (
    .clk(clk), .rst_n(rst_n), .in_pins(in_pins), .oe_n(oe_n),
    .preload(preload), .fuse_map(fm), .pin_in(pin_in),
    .pin_out(pin_out), .pin_oe(pin_oe)
  );

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // R1: row r, column c -> bit r*40+c ; 1 = blown
  task automatic blow_row(input int r);
    fm[r*NCOL +: NCOL] = '1;
  endtask
  task automatic keep(input int r, input int c);
    fm[r*NCOL + c] = 1'b0;
  endtask

  function automatic int count_now();
    return int'(~pin_out[5:2]) & 15;
  endfunction

  task automatic step();
    @(negedge clk); #1;
  endtask

  task automatic finish_run();
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    #800000;
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog expired actual=1 expected=0");
      finish_run();
    end
  end

  initial begin
    rst_n = 1'b0; oe_n = 1'b0; preload = 1'b0;
    in_pins = '0; pin_in = '0;
    fm = '0;
    // counter: q bit i at macrocell 2+i, signal 14+i, columns 28+2i / 29+2i
    blow_row(16); keep(16, 29);
    blow_row(24); keep(24, 30); keep(24, 29);
    blow_row(25); keep(25, 31); keep(25, 28);
    blow_row(32); keep(32, 32); keep(32, 31);
    blow_row(33); keep(33, 32); keep(33, 29);
    blow_row(34); keep(34, 33); keep(34, 30); keep(34, 28);
    blow_row(40); keep(40, 34); keep(40, 33);
    blow_row(41); keep(41, 34); keep(41, 31);
    blow_row(42); keep(42, 34); keep(42, 29);
    blow_row(43); keep(43, 35); keep(43, 32); keep(43, 30); keep(43, 28);
    // macrocell 0: enable = in0, data = in1 & in2
    blow_row(0); keep(0, 0);
    blow_row(1); keep(1, 2); keep(1, 4);
    // macrocell 6: enable and one data term fully blown
    blow_row(48); blow_row(49);
    // macrocell 7: enable blown, data = pin_in[1] (signal 13, column 26)
    blow_row(56); blow_row(57); keep(57, 26);

    step(); step(); step();
    check("R7 reset pins", int'(pin_out[5:2]), 15);
    check("R5 reset oe", int'(pin_oe[5:2]), 15);

    @(negedge clk); rst_n = 1'b1; #1;
    step(); check("R9 first edge holds", count_now(), 0);
    step(); check("R9 second edge holds", count_now(), 0);
    step(); check("R9 third edge loads", count_now(), 1);
    exp_cnt = 1;
    for (int i = 0; i < 20; i++) begin
      step();
      exp_cnt = (exp_cnt + 1) % 16;
      pin_in = 8'(i * 37);
      check("R3 count step", count_now(), exp_cnt);
    end

    // combinational sweep
    for (int v = 0; v < 8; v++) begin
      in_pins[2:0] = 3'(v);
      pin_in[1] = v[0];
      #1;
      check("R4 enable term", int'(pin_oe[0]), v & 1);
      check("R4 data inverse", int'(pin_out[0]), ((v >> 1) & (v >> 2) & 1) ? 0 : 1);
      check("R6 io feedback", int'(pin_out[7]), v[0] ? 0 : 1);
    end
    check("R2 both columns kept", int'({pin_oe[1], pin_out[1]}), 1);
    check("R2 all blown", int'({pin_oe[6], pin_out[6]}), 2);

    oe_n = 1'b1; #1;
    check("R5 oe_n high", int'(pin_oe[5:2]), 0);
    oe_n = 1'b0; #1;
    check("R5 oe_n low", int'(pin_oe[5:2]), 15);

    // preload against counting on the same edges
    for (int p = 0; p < 4; p++) begin
      logic [3:0] pat;
      pat = (p == 0) ? 4'hA : (p == 1) ? 4'hF : (p == 2) ? 4'h0 : 4'h9;
      @(negedge clk); preload = 1'b1; pin_in[5:2] = pat; #1;
      check("R8 pins released", int'(pin_oe[5:2]), 0);
      step();
      step();
      check("R8 still released", int'(pin_oe[5:2]), 0);
      @(negedge clk); preload = 1'b0; pin_in[5:2] = ~pat; #1;
      check("R8 preloaded level", int'(pin_out[5:2]), int'(pat));
      exp_cnt = int'(~pat) & 15;
      for (int i = 0; i < 3; i++) begin
        step();
        exp_cnt = (exp_cnt + 1) % 16;
        check("R8 resume count", count_now(), exp_cnt);
      end
    end

    // asynchronous clear mid-count
    @(negedge clk); rst_n = 1'b0; #1;
    check("R7 async clear", int'(pin_out[5:2]), 15);
    @(negedge clk); rst_n = 1'b1; #1;
    step(); check("R9 restart hold", count_now(), 0);
    step(); check("R9 restart hold 2", count_now(), 0);
    step(); check("R9 restart load", count_now(), 1);

    done = 1;
    finish_run();
  end
endmodule